// File: doc/BRIEF.md
# Programmable Interval Timer Peripheral with Interrupt Control

This block is a byte-wide, memory-mapped peripheral with sixteen register slots behind a 4-bit register select. Its core is a 16-bit down-counter with a pair of reload latches. Writing the upper counter byte starts the counter. When the counter underflows, it sets an interrupt flag. A mode bit picks the behaviour after the underflow. In single-shot mode the flag is raised once per start. In periodic mode the counter reloads from the latches and raises the flag on every underflow.

A flag register and an enable register combine into an active-low interrupt request. Both use a set/clear write convention. A read of the lower counter byte acknowledges the timer interrupt, so a service routine can clear the request with one read. Two output ports and their direction registers are kept as plain read/write storage and are driven out as pins. The counter advances only on cycles where the count-enable input is high, which lets the timer run from a slower time base than the bus clock.

Top module: `prog_timer`

## Requirements
- R1: After reset the port, direction, mode, flag and enable registers are all zero, reading the flag register (offset 0xD) returns 0x00, reading the enable register (offset 0xE) returns 0x80, and irq_no is high.
- R2: Offsets 0x0 (port B), 0x1 (port A), 0x2 (port B direction), 0x3 (port A direction), 0xB (mode) and 0xC (port control) are plain read/write registers. Offset 0xF reads and writes the same storage as 0x1. pa_o, pb_o, pa_dir_o and pb_dir_o show the stored values.
- R3: A write to offset 0x4 or 0x6 changes only the low reload latch, which reads back at 0x6. The counter is unchanged.
- R4: A write to offset 0x7 changes only the high reload latch. A write to offset 0x5 stores the high latch, loads the counter with {written byte, low latch}, clears the timer flag (bit 6) and arms the timer.
- R5: The counter decrements by one on each clock with tick_i high and holds otherwise. Reads at 0x4 and 0x5 return its low and high bytes.
- R6: In single-shot mode (mode bit 6 = 0), after a load of N the timer flag sets on the (N+1)-th tick, when the count wraps from 0 to 0xFFFF. No later wrap sets it again until the next write to 0x5.
- R7: In periodic mode (mode bit 6 = 1), the tick after an underflow reloads the counter from the latches, so the flag sets every N+2 ticks.
- R8: A read of offset 0x4 clears the timer flag.
- R9: Writing the flag register clears each of bits 6..0 that is written as 1. Bit 7 is not writable. Bit 7 reads as 1 exactly when some flag is set together with its enable.
- R10: A write to the enable register with bit 7 = 1 sets the enable bits written as 1. With bit 7 = 0 it clears them. Bit 7 always reads as 1.
- R11: irq_no is low exactly when some flag bit is set together with its enable bit.
- R12: Offsets 0x8, 0x9 and 0xA read as 0x00, and writes to them change no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter count enable |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rs_i | input | 4 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational, zero when not reading |
| irq_no | output | 1 | Interrupt request, active low |
| pa_o | output | 8 | Port A register |
| pb_o | output | 8 | Port B register |
| pa_dir_o | output | 8 | Port A direction register |
| pb_dir_o | output | 8 | Port B direction register |

## Verification
A wrong count or a dropped reload appears at the ports as a flag that arrives one or more ticks early or late. The bench catches this because it reads the flag register at the exact tick counts where the flag must still be clear and where it must be set. A stale arming bit would show up only after a full wrap of the 16-bit count, so the bench runs one single-shot wrap of 65536 ticks. An enable or flag bit stuck in a wrong state appears at once on irq_no and in bit 7 of the flag register. These are compared on the same cycle as the register write that changed them.

// File: rtl/prog_timer_pkg.sv
package prog_timer_pkg;
  typedef enum logic [3:0] {
    REG_PB   = 4'h0,
    REG_PA   = 4'h1,
    REG_DB   = 4'h2,
    REG_DA   = 4'h3,
    REG_CL   = 4'h4,
    REG_CH   = 4'h5,
    REG_LL   = 4'h6,
    REG_LH   = 4'h7,
    REG_X0   = 4'h8,
    REG_X1   = 4'h9,
    REG_X2   = 4'hA,
    REG_MODE = 4'hB,
    REG_PCTL = 4'hC,
    REG_FLG  = 4'hD,
    REG_ENA  = 4'hE,
    REG_PA2  = 4'hF
  } reg_e;

  localparam int T1_BIT   = 6;  // timer flag/enable position
  localparam int FREE_BIT = 6;  // periodic mode bit in mode register

  // plain store slots
  localparam int S_PB = 0;
  localparam int S_PA = 1;
  localparam int S_DB = 2;
  localparam int S_DA = 3;
  localparam int S_MD = 4;
  localparam int S_PC = 5;
  localparam int N_STORE = 6;
endpackage

// File: rtl/prog_timer_store.sv
module prog_timer_store #(
  parameter int DW = 8,
  parameter int NR = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NR-1:0]         we_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [NR-1:0][DW-1:0] q_o
);
  for (genvar i = 0; i < NR; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_o[i] <= '0;
      else if (we_i[i]) q_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/prog_timer_cnt.sv
module prog_timer_cnt #(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          free_i,
  input  logic          lo_we_i,
  input  logic          hi_we_i,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] lat_o,
  output logic          uf_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [DW-1:0] lat_lo_q, lat_hi_q;
  logic [CW-1:0] cnt_q;
  logic          pend_q, armed_q;
  logic          at_zero;

  assign at_zero = (cnt_q == '0) && !pend_q;
  assign uf_o    = tick_i && !load_i && at_zero && armed_q;
  assign cnt_o   = cnt_q;
  assign lat_o   = {lat_hi_q, lat_lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_lo_q <= '0;
      lat_hi_q <= '0;
    end else begin
      if (lo_we_i)           lat_lo_q <= wdata_i;
      if (hi_we_i || load_i) lat_hi_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= {wdata_i, lat_lo_q};
      pend_q  <= 1'b0;
      armed_q <= 1'b1;
    end else if (tick_i) begin
      if (pend_q) begin
        cnt_q  <= {lat_hi_q, lat_lo_q};
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - ONE;
        if (at_zero) begin
          // wrap: periodic reloads next tick, single-shot disarms
          if (free_i) pend_q  <= 1'b1;
          else        armed_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/prog_timer_irq.sv
module prog_timer_irq #(
  parameter int NF = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] ack_i,
  input  logic          flg_we_i,
  input  logic          ena_we_i,
  input  logic [NF:0]   wdata_i,
  output logic [NF-1:0] flg_o,
  output logic [NF-1:0] ena_o,
  output logic          irq_no
);
  logic [NF-1:0] flg_q, ena_q, wclr;

  assign wclr = flg_we_i ? wdata_i[NF-1:0] : '0;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~ack_i & ~wclr) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ena_q <= '0;
    else if (ena_we_i) begin
      if (wdata_i[NF]) ena_q <= ena_q | wdata_i[NF-1:0];
      else             ena_q <= ena_q & ~wdata_i[NF-1:0];
    end
  end

  assign flg_o  = flg_q;
  assign ena_o  = ena_q;
  assign irq_no = ~|(flg_q & ena_q);
endmodule

// File: rtl/prog_timer.sv
module prog_timer
  import prog_timer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [3:0]    rs_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_no,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pa_dir_o,
  output logic [DW-1:0] pb_dir_o
);
  localparam int CW = 2 * DW;
  localparam int NF = DW - 1;

  logic                       wr_en, rd_en;
  logic [N_STORE-1:0]         st_we;
  logic [N_STORE-1:0][DW-1:0] st_q;
  logic [CW-1:0]              cnt_w, lat_w;
  logic                       uf_w, rd_lo;
  logic [NF-1:0]              set_v, ack_v, flg_w, ena_w;
  logic                       t1_flag;

  assign wr_en = cs_i && wr_i;
  assign rd_en = cs_i && rd_i;
  assign rd_lo = rd_en && (rs_i == REG_CL);

  always_comb begin
    st_we       = '0;
    st_we[S_PB] = wr_en && (rs_i == REG_PB);
    st_we[S_PA] = wr_en && ((rs_i == REG_PA) || (rs_i == REG_PA2));
    st_we[S_DB] = wr_en && (rs_i == REG_DB);
    st_we[S_DA] = wr_en && (rs_i == REG_DA);
    st_we[S_MD] = wr_en && (rs_i == REG_MODE);
    st_we[S_PC] = wr_en && (rs_i == REG_PCTL);
  end

  prog_timer_store #(.DW(DW), .NR(N_STORE)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (st_we),
    .wdata_i (wdata_i),
    .q_o     (st_q)
  );

  prog_timer_cnt #(.DW(DW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .free_i  (st_q[S_MD][FREE_BIT]),
    .lo_we_i (wr_en && ((rs_i == REG_CL) || (rs_i == REG_LL))),
    .hi_we_i (wr_en && (rs_i == REG_LH)),
    .load_i  (wr_en && (rs_i == REG_CH)),
    .wdata_i (wdata_i),
    .cnt_o   (cnt_w),
    .lat_o   (lat_w),
    .uf_o    (uf_w)
  );

  always_comb begin
    set_v         = '0;
    ack_v         = '0;
    set_v[T1_BIT] = uf_w;
    ack_v[T1_BIT] = rd_lo || (wr_en && (rs_i == REG_CH));
  end

  prog_timer_irq #(.NF(NF)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_v),
    .ack_i    (ack_v),
    .flg_we_i (wr_en && (rs_i == REG_FLG)),
    .ena_we_i (wr_en && (rs_i == REG_ENA)),
    .wdata_i  (wdata_i),
    .flg_o    (flg_w),
    .ena_o    (ena_w),
    .irq_no   (irq_no)
  );

  assign t1_flag = flg_w[T1_BIT];

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      case (rs_i)
        REG_PB:           rdata_o = st_q[S_PB];
        REG_PA, REG_PA2:  rdata_o = st_q[S_PA];
        REG_DB:           rdata_o = st_q[S_DB];
        REG_DA:           rdata_o = st_q[S_DA];
        REG_CL:           rdata_o = cnt_w[DW-1:0];
        REG_CH:           rdata_o = cnt_w[CW-1:DW];
        REG_LL:           rdata_o = lat_w[DW-1:0];
        REG_LH:           rdata_o = lat_w[CW-1:DW];
        REG_MODE:         rdata_o = st_q[S_MD];
        REG_PCTL:         rdata_o = st_q[S_PC];
        REG_FLG:          rdata_o = {~irq_no, flg_w};
        REG_ENA:          rdata_o = {1'b1, ena_w};
        default:          rdata_o = '0;
      endcase
    end
  end

  assign pa_o     = st_q[S_PA];
  assign pb_o     = st_q[S_PB];
  assign pa_dir_o = st_q[S_DA];
  assign pb_dir_o = st_q[S_DB];
endmodule

// File: rtl/prog_timer_chk.sv
module prog_timer_chk #(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          cs_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic [3:0]    rs_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          irq_no,
  input logic [CW-1:0] cnt_w,
  input logic [CW-1:0] lat_w,
  input logic          uf_w,
  input logic          t1_flag
);
  logic load_wr, lo_rd;
  assign load_wr = cs_i && wr_i && (rs_i == 4'h5);
  assign lo_rd   = cs_i && rd_i && (rs_i == 4'h4);

  a_r4_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_wr |=> (cnt_w == {$past(wdata_i), $past(lat_w[DW-1:0])}) && !t1_flag);

  a_r5_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_wr) |=> $stable(cnt_w));

  a_r6_underflow_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_w |=> t1_flag);

  a_r8_read_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_rd && !uf_w) |=> !t1_flag);

  a_r9_flag_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && rs_i == 4'hD) |-> (rdata_o[DW-1] == !irq_no));

  a_r10_ena_top_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && rs_i == 4'hE) |-> rdata_o[DW-1]);
endmodule

bind prog_timer prog_timer_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .cs_i    (cs_i),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .rs_i    (rs_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_no  (irq_no),
  .cnt_w   (cnt_w),
  .lat_w   (lat_w),
  .uf_w    (uf_w),
  .t1_flag (t1_flag)
);

// File: tb/sim_prog_timer.sv
module sim_prog_timer;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, cs = 1'b0, rd_s = 1'b0, wr_s = 1'b0;
  logic [3:0] rs = '0;
  logic [7:0] wd = '0;
  logic [7:0] rdata, pa, pb, pa_dir, pb_dir;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  prog_timer u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .cs_i     (cs),
    .rd_i     (rd_s),
    .wr_i     (wr_s),
    .rs_i     (rs),
    .wdata_i  (wd),
    .rdata_o  (rdata),
    .irq_no   (irq_n),
    .pa_o     (pa),
    .pb_o     (pb),
    .pa_dir_o (pa_dir),
    .pb_dir_o (pb_dir)
  );

  // monitor: pops the expected read value while the read strobe is live
  always @(negedge clk) begin
    if (cs && rd_s) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read act=%02h exp=none", rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rdata !== e.v) begin
          errors++;
          $display("FAIL %s rs=%h act=%02h exp=%02h", e.tag, rs, rdata, e.v);
        end
      end
    end
  end

  // all tasks start and end 1 time unit after a rising edge
  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    cs = 1; wr_s = 1; rs = a; wd = d;
    @(posedge clk); #1;
    cs = 0; wr_s = 0;
  endtask

  task automatic reg_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back('{e, tag});
    cs = 1; rd_s = 1; rs = a;
    @(posedge clk); #1;
    cs = 0; rd_s = 0;
  endtask

  task automatic ticks(input int n);
    tick = 1;
    repeat (n) @(posedge clk);
    #1 tick = 0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    reg_rd(4'h0, 8'h00, "R1 port B reset");
    reg_rd(4'hD, 8'h00, "R1 flags reset");
    reg_rd(4'hE, 8'h80, "R1 enable reset");
    reg_rd(4'hB, 8'h00, "R1 mode reset");
    chk({7'd0, irq_n}, 8'h01, "R1 irq idle");

    // R2 plain registers and alias
    reg_wr(4'h0, 8'hA5);
    reg_wr(4'h1, 8'h3C);
    reg_wr(4'h2, 8'h07);
    reg_wr(4'h3, 8'hFF);
    reg_wr(4'hC, 8'h5A);
    reg_rd(4'h0, 8'hA5, "R2 port B");
    reg_rd(4'h1, 8'h3C, "R2 port A");
    reg_rd(4'h2, 8'h07, "R2 dir B");
    reg_rd(4'h3, 8'hFF, "R2 dir A");
    reg_rd(4'hC, 8'h5A, "R2 port ctl");
    chk(pa, 8'h3C, "R2 pa_o");
    chk(pb_dir, 8'h07, "R2 pb_dir_o");
    chk(pa_dir, 8'hFF, "R2 pa_dir_o");
    reg_wr(4'hF, 8'h51);
    reg_rd(4'h1, 8'h51, "R2 alias write");
    reg_rd(4'hF, 8'h51, "R2 alias read");
    chk(pa, 8'h51, "R2 pa_o alias");
    chk(pb, 8'hA5, "R2 pb_o");

    // R12 unused slots
    reg_wr(4'h8, 8'h77);
    reg_wr(4'h9, 8'h66);
    reg_wr(4'hA, 8'h55);
    reg_rd(4'h8, 8'h00, "R12 slot 8");
    reg_rd(4'h9, 8'h00, "R12 slot 9");
    reg_rd(4'hA, 8'h00, "R12 slot A");
    reg_rd(4'h0, 8'hA5, "R12 port B kept");
    reg_rd(4'h6, 8'h00, "R12 latch kept");

    // R10 enable set/clear
    reg_wr(4'hE, 8'h7F);
    reg_rd(4'hE, 8'h80, "R10 clear all");
    reg_wr(4'hE, 8'hC0);
    reg_rd(4'hE, 8'hC0, "R10 set timer");
    reg_wr(4'hE, 8'h83);
    reg_rd(4'hE, 8'hC3, "R10 set more");
    reg_wr(4'hE, 8'h03);
    reg_rd(4'hE, 8'hC0, "R10 clear some");

    // R3 low latch only
    reg_wr(4'h6, 8'h09);
    reg_rd(4'h6, 8'h09, "R3 latch via 6");
    reg_wr(4'h4, 8'h05);
    reg_rd(4'h6, 8'h05, "R3 latch via 4");
    reg_rd(4'h4, 8'h00, "R3 counter untouched");

    // R4 high latch and load
    reg_wr(4'h7, 8'h12);
    reg_rd(4'h7, 8'h12, "R4 high latch");
    reg_rd(4'h5, 8'h00, "R4 counter untouched");
    reg_wr(4'h5, 8'h00);
    reg_rd(4'h4, 8'h05, "R4 load low");
    reg_rd(4'h5, 8'h00, "R4 load high");
    reg_rd(4'h7, 8'h00, "R4 high latch on load");

    // R5/R6 single-shot from 5
    ticks(3);
    reg_rd(4'h4, 8'h02, "R5 count down");
    ticks(2);
    reg_rd(4'h4, 8'h00, "R5 at zero");
    reg_rd(4'hD, 8'h00, "R6 no flag at zero");
    chk({7'd0, irq_n}, 8'h01, "R11 no irq yet");
    ticks(1);
    reg_rd(4'hD, 8'hC0, "R6 flag on wrap");
    chk({7'd0, irq_n}, 8'h00, "R11 irq asserted");
    reg_rd(4'h5, 8'hFF, "R6 wrapped high");
    reg_rd(4'h4, 8'hFF, "R8 ack read value");
    reg_rd(4'hD, 8'h00, "R8 flag cleared");
    chk({7'd0, irq_n}, 8'h01, "R8 irq released");
    ticks(65536);
    reg_rd(4'hD, 8'h00, "R6 no retrigger");
    reg_rd(4'h5, 8'hFF, "R6 full wrap high");

    // R7 periodic from 3: period 5
    reg_wr(4'hB, 8'h40);
    reg_wr(4'h4, 8'h03);
    reg_wr(4'h5, 8'h00);
    ticks(3);
    reg_rd(4'hD, 8'h00, "R7 early");
    ticks(1);
    reg_rd(4'hD, 8'hC0, "R7 first flag");
    ticks(1);
    reg_rd(4'h4, 8'h03, "R7 reload");
    reg_rd(4'hD, 8'h00, "R8 cleared in periodic");
    ticks(3);
    reg_rd(4'hD, 8'h00, "R7 before second");
    ticks(1);
    reg_rd(4'hD, 8'hC0, "R7 second flag");

    // R9/R11 masking and flag writes
    reg_wr(4'hE, 8'h40);
    reg_rd(4'hE, 8'h80, "R10 timer disabled");
    chk({7'd0, irq_n}, 8'h01, "R11 masked");
    reg_rd(4'hD, 8'h40, "R9 summary off when masked");
    reg_wr(4'hD, 8'h80);
    reg_rd(4'hD, 8'h40, "R9 bit7 not writable");
    reg_wr(4'hE, 8'hC0);
    chk({7'd0, irq_n}, 8'h00, "R11 unmasked");
    reg_rd(4'hD, 8'hC0, "R9 summary on");
    reg_wr(4'hD, 8'h40);
    reg_rd(4'hD, 8'h00, "R9 write-one clear");
    chk({7'd0, irq_n}, 8'h01, "R11 released");

    // R4 load clears pending flag
    ticks(5);
    reg_rd(4'hD, 8'hC0, "R7 third flag");
    reg_wr(4'h4, 8'h02);
    reg_wr(4'h5, 8'h00);
    reg_rd(4'hD, 8'h00, "R4 load clears flag");
    reg_rd(4'h4, 8'h02, "R4 reload value");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard act=%0d exp=0 pending", exp_q.size());
    end
    finish_run();
  end
endmodule